// File: doc/BRIEF.md
# Bus Master Burst Termination Controller

This block sequences the control side of a bus master's burst on a PCI-style bus. It opens the address phase, runs data phases until the burst is finished, and then hands the bus back. A programmable latency timer limits how long the master may keep the bus after grant is taken away. If no target claims the cycle soon enough, the block ends the cycle as a master abort. It then sets its abort status and system-interrupt flags and signals a fatal error to the rest of the device. That fatal signal is what resets the operational control registers there. Configuration registers elsewhere are left alone.

All bus controls on the ports are active high. Pad inversion and tristate control sit outside this block. The same applies to address/data driving, parity and target decoding. Software supplies the latency value, the burst length in data phases and the interrupt enable. It clears the flags with write-one strobes.

Top module: `bus_master_term`

## Requirements
- R1: While reset is held and on the first cycle after it, frame, irdy, bus_release, fatal_err, rma_flag, sint_flag and inta are all 0.
- R2: In idle, start_req with gnt high starts one address cycle (frame=1, irdy=0). The next cycle has irdy=1. start_req while gnt is low is ignored and frame stays 0.
- R3: A data phase completes in a cycle with irdy, trdy and devsel all high. A burst of N phases (N=0 treated as 1) keeps frame high until its final phase. The final phase has frame=0 and irdy=1. bus_release is 1 for exactly the cycle after the final phase completes, with frame=irdy=0.
- R4: A cycle with trdy low completes no phase, and the frame/irdy levels hold.
- R5: The latency counter loads lat_value in the cycle the burst starts and counts down once per clock, stopping at 0. While gnt stays high, the burst runs to its full length whatever the counter holds.
- R6: If a phase completes while gnt is low and the counter is 0, the next phase is the final one.
- R7: If gnt is low while the counter is still nonzero, the burst continues until the counter runs out or the length is reached.
- R8: Data cycles after the address cycle are numbered 1, 2, … If devsel is low in all of cycles 1 to 4, cycle 5 is an abort cycle with fatal_err=1, frame=0 and irdy=1. Cycle 6 has bus_release=1, and no phase completes. devsel first seen in cycle 4 avoids the abort.
- R9: A master abort sets rma_flag and sint_flag, both visible in the abort cycle.
- R10: inta equals sint_flag AND int_en, at all times.
- R11: clr_rma clears rma_flag only, and clr_sint clears sint_flag only, each on the following cycle. A new abort takes priority over a clear in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_req | input | 1 | Request to begin a burst |
| burst_len | input | LEN_W | Number of data phases in the burst |
| lat_value | input | LAT_W | Programmed latency timer value |
| gnt | input | 1 | Bus grant from the arbiter |
| devsel | input | 1 | Target claims the cycle |
| trdy | input | 1 | Target ready |
| int_en | input | 1 | System-interrupt enable |
| clr_rma | input | 1 | Write-one strobe clearing rma_flag |
| clr_sint | input | 1 | Write-one strobe clearing sint_flag |
| frame | output | 1 | Cycle frame, active high |
| irdy | output | 1 | Initiator ready, active high |
| bus_release | output | 1 | One-cycle pulse when the bus is given back |
| fatal_err | output | 1 | One-cycle fatal-error pulse on master abort |
| rma_flag | output | 1 | Received-master-abort status |
| sint_flag | output | 1 | System-interrupt flag |
| inta | output | 1 | Interrupt request |

## Verification
Several burst patterns are run:

- Single-phase and multi-phase bursts with a ready target show that frame drops exactly on the final phase.
- A burst with target wait states shows that trdy, not the clock, advances the phase count.
- Three runs with grant withdrawn early are compared: timer already expired, timer still running, and timer loaded with zero. Together they separate preemption from the normal end of a burst.
- A target that never claims the cycle is compared with one that claims it in the last allowed cycle. This pins the abort window to exactly four cycles.
- The flag sequence checks interrupt gating and that each clear strobe affects only its own flag.

// File: rtl/bmt_pkg.sv
package bmt_pkg;
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_DATA,
    ST_LAST,
    ST_MABORT,
    ST_REL
  } bmt_state_e;
endpackage

// File: rtl/bmt_lat_timer.sv
// Latency timer: loads at burst start, counts down to zero and holds there.
module bmt_lat_timer #(
  parameter int LAT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic             run,
  input  logic [LAT_W-1:0] load_val,
  output logic             expired
);
  logic [LAT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)
      cnt_d = load_val;
    else if (run && (cnt_q != '0))
      cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expired = (cnt_q == '0);
endmodule

// File: rtl/bmt_claim_window.sv
// Tracks whether a target has claimed the cycle within WIN data cycles.
module bmt_claim_window #(
  parameter int WIN = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic arm,
  input  logic sample,
  input  logic devsel,
  output logic timeout
);
  localparam int CNT_W = $clog2(WIN + 1);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             seen_q, seen_d;
  logic             at_limit;

  assign at_limit = (cnt_q == CNT_W'(WIN));

  always_comb begin
    cnt_d  = cnt_q;
    seen_d = seen_q;
    if (arm) begin
      cnt_d  = CNT_W'(1);
      seen_d = 1'b0;
    end else if (sample && !seen_q) begin
      if (devsel)
        seen_d = 1'b1;
      else if (!at_limit)
        cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      seen_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      seen_q <= seen_d;
    end
  end

  assign timeout = sample && !seen_q && !devsel && at_limit;
endmodule

// File: rtl/bmt_status.sv
// Abort status and system-interrupt flags with write-one clear.
module bmt_status (
  input  logic clk,
  input  logic rst_n,
  input  logic set_abort,
  input  logic clr_rma,
  input  logic clr_sint,
  input  logic int_en,
  output logic rma,
  output logic sint,
  output logic inta
);
  logic rma_q, rma_d, sint_q, sint_d;

  always_comb begin
    rma_d  = rma_q;
    sint_d = sint_q;
    if (set_abort)     rma_d = 1'b1;
    else if (clr_rma)  rma_d = 1'b0;
    if (set_abort)     sint_d = 1'b1;
    else if (clr_sint) sint_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rma_q  <= 1'b0;
      sint_q <= 1'b0;
    end else begin
      rma_q  <= rma_d;
      sint_q <= sint_d;
    end
  end

  assign rma  = rma_q;
  assign sint = sint_q;
  assign inta = sint_q && int_en;
endmodule

// File: rtl/bus_master_term.sv
module bus_master_term
  import bmt_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int LAT_W = 8,
  parameter int WIN   = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start_req,
  input  logic [LEN_W-1:0] burst_len,
  input  logic [LAT_W-1:0] lat_value,
  input  logic             gnt,
  input  logic             devsel,
  input  logic             trdy,
  input  logic             int_en,
  input  logic             clr_rma,
  input  logic             clr_sint,
  output logic             frame,
  output logic             irdy,
  output logic             bus_release,
  output logic             fatal_err,
  output logic             rma_flag,
  output logic             sint_flag,
  output logic             inta
);
  bmt_state_e       st_q, st_d;
  logic [LEN_W-1:0] rem_q, rem_d;
  logic             launch, in_data, xfer, expired, timeout, abort_go;

  assign launch   = (st_q == ST_IDLE) && start_req && gnt;
  assign in_data  = (st_q == ST_DATA) || (st_q == ST_LAST);
  assign xfer     = in_data && trdy && devsel;
  assign abort_go = in_data && timeout;

  bmt_lat_timer #(.LAT_W(LAT_W)) u_lat (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (launch),
    .run      (st_q != ST_IDLE),
    .load_val (lat_value),
    .expired  (expired)
  );

  bmt_claim_window #(.WIN(WIN)) u_win (
    .clk     (clk),
    .rst_n   (rst_n),
    .arm     (launch),
    .sample  (in_data),
    .devsel  (devsel),
    .timeout (timeout)
  );

  bmt_status u_stat (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_abort (abort_go),
    .clr_rma   (clr_rma),
    .clr_sint  (clr_sint),
    .int_en    (int_en),
    .rma       (rma_flag),
    .sint      (sint_flag),
    .inta      (inta)
  );

  always_comb begin
    st_d  = st_q;
    rem_d = rem_q;
    unique case (st_q)
      ST_IDLE: begin
        if (launch) begin
          st_d  = ST_ADDR;
          rem_d = burst_len;
        end
      end
      ST_ADDR: st_d = (rem_q <= LEN_W'(1)) ? ST_LAST : ST_DATA;
      ST_DATA: begin
        if (timeout) begin
          st_d = ST_MABORT;
        end else if (xfer) begin
          rem_d = rem_q - 1'b1;
          if ((rem_q <= LEN_W'(2)) || (!gnt && expired))
            st_d = ST_LAST;
        end
      end
      ST_LAST: begin
        if (timeout)   st_d = ST_MABORT;
        else if (xfer) st_d = ST_REL;
      end
      ST_MABORT: st_d = ST_REL;
      ST_REL:    st_d = ST_IDLE;
      default:   st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      rem_q <= '0;
    end else begin
      st_q  <= st_d;
      rem_q <= rem_d;
    end
  end

  assign frame       = (st_q == ST_ADDR) || (st_q == ST_DATA);
  assign irdy        = (st_q == ST_DATA) || (st_q == ST_LAST) || (st_q == ST_MABORT);
  assign bus_release = (st_q == ST_REL);
  assign fatal_err   = (st_q == ST_MABORT);
endmodule

// File: rtl/bmt_checker.sv
module bmt_checker (
  input logic clk,
  input logic rst_n,
  input logic frame,
  input logic irdy,
  input logic trdy,
  input logic devsel,
  input logic bus_release,
  input logic fatal_err,
  input logic rma_flag,
  input logic sint_flag,
  input logic int_en,
  input logic inta,
  input logic clr_rma,
  input logic clr_sint
);
  assert_addr_no_irdy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame) |-> !irdy);

  assert_addr_then_irdy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame) |=> irdy);

  assert_release_after_final_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!frame && irdy && trdy && devsel) |=> bus_release);

  assert_release_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    bus_release |-> (!frame && !irdy));

  assert_abort_shape_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |-> (!frame && irdy));

  assert_abort_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |=> bus_release);

  assert_abort_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
    fatal_err |-> (rma_flag && sint_flag));

  assert_int_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !int_en |-> !inta);

  assert_rma_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_rma |=> (!rma_flag || fatal_err));

  assert_sint_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    clr_sint |=> (!sint_flag || fatal_err));
endmodule

bind bus_master_term bmt_checker u_bmt_checker (
  .clk         (clk),
  .rst_n       (rst_n),
  .frame       (frame),
  .irdy        (irdy),
  .trdy        (trdy),
  .devsel      (devsel),
  .bus_release (bus_release),
  .fatal_err   (fatal_err),
  .rma_flag    (rma_flag),
  .sint_flag   (sint_flag),
  .int_en      (int_en),
  .inta        (inta),
  .clr_rma     (clr_rma),
  .clr_sint    (clr_sint)
);

// File: tb/bus_master_term_test.sv
`timescale 1ns/1ps
module bus_master_term_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start_req, gnt, devsel, trdy, int_en, clr_rma, clr_sint;
  logic [7:0] burst_len, lat_value;
  logic       frame, irdy, bus_release, fatal_err, rma_flag, sint_flag, inta;

  int n_checks = 0;
  int n_fail   = 0;

  always #10 clk = ~clk;

  bus_master_term uut (
    .clk(clk), .rst_n(rst_n), .start_req(start_req), .burst_len(burst_len),
    .lat_value(lat_value), .gnt(gnt), .devsel(devsel), .trdy(trdy),
    .int_en(int_en), .clr_rma(clr_rma), .clr_sint(clr_sint),
    .frame(frame), .irdy(irdy), .bus_release(bus_release),
    .fatal_err(fatal_err), .rma_flag(rma_flag), .sint_flag(sint_flag),
    .inta(inta)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic chk_eq(input string req, input string what, input int act, input int exp);
    check(act == exp, req, what, act, exp);
  endtask

  // Runs one burst. devsel is high from cycle dev_from (0 = never); trdy follows devsel
  // except in cycle wait_cyc; gnt drops from cycle gnt_off on (0 = never).
  task automatic run_burst(input int len, input int lat, input int gnt_off,
                           input int dev_from, input int wait_cyc,
                           output int beats, output int last_cyc, output int rel_cyc,
                           output int fatal_cyc, output int shape_err);
    beats = 0; last_cyc = 0; rel_cyc = 0; fatal_cyc = 0; shape_err = 0;
    @(negedge clk);
    start_req = 1'b1; gnt = 1'b1; burst_len = 8'(len); lat_value = 8'(lat);
    devsel = 1'b0; trdy = 1'b0;
    @(negedge clk);
    chk_eq("R2", "address cycle frame", int'(frame), 1);
    chk_eq("R2", "address cycle irdy", int'(irdy), 0);
    start_req = 1'b0;
    for (int k = 1; k <= 60; k++) begin
      @(negedge clk);
      gnt    = (gnt_off != 0 && k >= gnt_off) ? 1'b0 : 1'b1;
      devsel = (dev_from != 0 && k >= dev_from) ? 1'b1 : 1'b0;
      trdy   = devsel && (k != wait_cyc);
      if (bus_release) begin
        rel_cyc = k;
        if (frame || irdy) shape_err++;
        break;
      end
      if (fatal_err && fatal_cyc == 0) fatal_cyc = k;
      if (!frame && irdy && last_cyc == 0) last_cyc = k;
      if (last_cyc == 0 && !(frame && irdy)) shape_err++;
      if (irdy && trdy && devsel && !fatal_err) beats++;
    end
    @(negedge clk);
    gnt = 1'b0; devsel = 1'b0; trdy = 1'b0;
  endtask

  task automatic t_reset();
    chk_eq("R1", "frame after reset", int'(frame), 0);
    chk_eq("R1", "irdy after reset", int'(irdy), 0);
    chk_eq("R1", "release after reset", int'(bus_release), 0);
    chk_eq("R1", "fatal after reset", int'(fatal_err), 0);
    chk_eq("R1", "flags after reset", int'(rma_flag) + int'(sint_flag) + int'(inta), 0);
  endtask

  task automatic t_no_grant();
    int seen = 0;
    start_req = 1'b1; gnt = 1'b0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk);
      if (frame) seen++;
    end
    start_req = 1'b0;
    chk_eq("R2", "frame without grant", seen, 0);
  endtask

  task automatic t_burst(input string req, input int len, input int lat, input int goff,
                         input int dfrom, input int wc, input int e_beats,
                         input int e_last, input int e_rel, input int e_fatal);
    int b, l, r, f, s;
    run_burst(len, lat, goff, dfrom, wc, b, l, r, f, s);
    chk_eq(req, "completed phases", b, e_beats);
    chk_eq(req, "final phase cycle", l, e_last);
    chk_eq(req, "release cycle", r, e_rel);
    chk_eq(req, "fatal cycle", f, e_fatal);
    chk_eq(req, "frame/irdy shape errors", s, 0);
  endtask

  task automatic t_flags();
    int_en = 1'b0;
    t_burst("R8", 4, 10, 0, 0, 0, 0, 5, 6, 5);
    chk_eq("R9", "rma after abort", int'(rma_flag), 1);
    chk_eq("R9", "sint after abort", int'(sint_flag), 1);
    chk_eq("R10", "inta gated off", int'(inta), 0);
    int_en = 1'b1;
    #1;
    chk_eq("R10", "inta enabled", int'(inta), 1);
    @(negedge clk); clr_rma = 1'b1;
    @(negedge clk); clr_rma = 1'b0;
    chk_eq("R11", "rma cleared", int'(rma_flag), 0);
    chk_eq("R11", "sint kept by rma clear", int'(sint_flag), 1);
    chk_eq("R10", "inta still high", int'(inta), 1);
    @(negedge clk); clr_sint = 1'b1;
    @(negedge clk); clr_sint = 1'b0;
    chk_eq("R11", "sint cleared", int'(sint_flag), 0);
    chk_eq("R10", "inta dropped", int'(inta), 0);
  endtask

  initial begin
    #2000000;
    n_fail++; n_checks++;
    $display("FAIL watchdog: actual 1 expected 0");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    rst_n = 1'b0; start_req = 1'b0; gnt = 1'b0; devsel = 1'b0; trdy = 1'b0;
    int_en = 1'b0; clr_rma = 1'b0; clr_sint = 1'b0; burst_len = '0; lat_value = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_no_grant();
    // R3: three phases, ready target
    t_burst("R3", 3, 20, 0, 1, 0, 3, 3, 4, 0);
    // R3: single phase
    t_burst("R3", 1, 20, 0, 1, 0, 1, 1, 2, 0);
    // R4: wait state in cycle 2
    t_burst("R4", 3, 20, 0, 1, 2, 3, 4, 5, 0);
    // R5: grant held past timer expiry, full length
    t_burst("R5", 6, 2, 0, 1, 0, 6, 6, 7, 0);
    // R6: grant dropped, timer expires in cycle 2
    t_burst("R6", 10, 2, 1, 1, 0, 3, 3, 4, 0);
    // R6: timer loaded with zero
    t_burst("R6", 10, 0, 1, 1, 0, 2, 2, 3, 0);
    // R7: grant dropped, timer still running, burst completes
    t_burst("R7", 5, 8, 1, 1, 0, 5, 5, 6, 0);
    // R8: devsel first in cycle 4, no abort
    t_burst("R8", 2, 20, 0, 4, 0, 2, 5, 6, 0);
    t_flags();
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule